// File: doc/BRIEF.md
# Serial Target Shift Engine

This block is the host-side master of a three-wire serial programming link. It produces a bit clock, a mode/select line and a data line towards a target device, and it reads back one data line from that target. A command gives a mode (boundary-scan shifting, SPI master transfer or slave-serial streaming), a bit count of up to `MAX_BITS`, the outgoing data bits, the per-bit mode-select bits and a capture delay. When the command completes, the engine returns the bits it captured.

The bit clock has six rate codes. Each code halves the rate of the code before it. The link follows one timing discipline throughout. Outgoing lines are launched on the falling edge of the bit clock, so the target samples them on the rising edge. The engine samples the returning line a programmable number of system clocks after the rising edge, which leaves time for the round trip through the cable. The three output drivers are enabled only while a command runs. Before they are released to high-Z, the lines are parked high for one half period.

Top module: `sti_shift_engine`

## Requirements
- R1: A rate write with code 1..6 while idle sets the bit-clock half period to `HALF_BASE << (code-1)` system clocks. A write of code 0 or 7, or any write while busy, is ignored.
- R2: After reset the rate code is 3, which gives a half period of `4*HALF_BASE` system clocks.
- R3: While the drivers are enabled, `dat_o` and `sel_o` change only in the cycle where `clk_o` falls. The first bit is launched with `clk_o` low when the drivers turn on.
- R4: The input `din` is sampled `cap_dly+1` system clocks after `clk_o` rises.
- R5: With mode 1 (SPI), `sel_o` is low for every bit of the transfer. With mode 2 (slave-serial), `sel_o` is high for every bit.
- R6: `clk_oe`, `sel_oe` and `dat_oe` are high only while a command runs, and low out of reset and between commands.
- R7: After the last falling edge of `clk_o`, `dat_o` and `sel_o` are driven to 1 with `clk_o` low for one half period. The drivers are then released.
- R8: A command is rejected if its mode is 3, its bit count is 0 or above `MAX_BITS`, or its `cmd_cap` is not smaller than the current half period. A rejected command pulses `err` for one cycle and starts nothing.
- R9: In mode 0 (boundary-scan), clock j launches `cmd_dout[j]` on `dat_o` and `cmd_tms[j]` on `sel_o`, and the bit captured on clock j lands in `rx_data[j]`. Mode 2 orders its data the same way.
- R10: In mode 1 (SPI), clock j launches `cmd_dout[n-1-j]` and stores its captured bit in `rx_data[n-1-j]`. The `rx_data` bits at positions n and above read 0.
- R11: `busy` rises in the cycle after a command is accepted. `done` pulses for one cycle in the cycle where `busy` falls and the drivers release.
- R12: `clk_o` idles low and makes exactly n full periods, each high for one half period, for an n-bit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_wr | input | 1 | Write strobe for the rate code |
| rate_sel | input | 3 | Rate code, 1 (fastest) to 6 |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_mode | input | 2 | 0 boundary-scan, 1 SPI, 2 slave-serial |
| cmd_nbits | input | $clog2(MAX_BITS+1) | Number of bits to shift |
| cmd_dout | input | MAX_BITS | Outgoing data bits |
| cmd_tms | input | MAX_BITS | Per-bit mode-select bits (mode 0) |
| cmd_cap | input | $clog2(HALF_BASE*32+1) | Capture delay in system clocks |
| din | input | 1 | Data returned by the target |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejected-command pulse |
| rx_data | output | MAX_BITS | Captured bits |
| clk_o | output | 1 | Bit clock to the target |
| clk_oe | output | 1 | Driver enable for the bit clock |
| sel_o | output | 1 | Mode/select line |
| sel_oe | output | 1 | Driver enable for the mode/select line |
| dat_o | output | 1 | Data line to the target |
| dat_oe | output | 1 | Driver enable for the data line |

## Verification
The capture instant is the hardest behaviour to see from the ports, because a sample taken one cycle early or late usually reads the same value. The bench acts as the target. After each rising edge of `clk_o`, it drives the inverse of the intended bit and switches to the true bit only half a system clock before the required sampling instant. A capture taken too early therefore returns wrong data. Commands run at the fastest and slowest rates, and one uses a capture delay of exactly one less than the half period, so that each window edge is exercised.

// File: rtl/sti_pkg.sv
`timescale 1ns/1ps
package sti_pkg;
  typedef enum logic [1:0] {
    MD_JTAG = 2'd0,
    MD_SPI  = 2'd1,
    MD_SER  = 2'd2,
    MD_BAD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_PARK
  } st_e;

  localparam logic [2:0] RATE_RST = 3'd3;
  localparam logic [2:0] RATE_MIN = 3'd1;
  localparam logic [2:0] RATE_MAX = 3'd6;
  localparam int         N_RATES  = 6;
endpackage

// File: rtl/sti_rate_ctl.sv
`timescale 1ns/1ps
module sti_rate_ctl
  import sti_pkg::*;
#(
  parameter int HALF_BASE = 2,
  parameter int HW        = $clog2(HALF_BASE*32+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    code,
  input  logic          busy,
  output logic [HW-1:0] half
);
  logic [2:0]    rate_q, rate_d;
  logic [HW-1:0] half_tab [N_RATES];

  for (genvar g = 0; g < N_RATES; g++) begin : g_tab
    assign half_tab[g] = HW'(HALF_BASE) << g;
  end

  always_comb begin
    rate_d = rate_q;
    if (wr && !busy && code >= RATE_MIN && code <= RATE_MAX) rate_d = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= RATE_RST;
    else        rate_q <= rate_d;
  end

  assign half = half_tab[rate_q - 3'd1];

  AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q >= RATE_MIN && rate_q <= RATE_MAX)) else $error("rate code out of range"); // R1
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rate_q)) else $error("rate changed while busy"); // R1
endmodule

// File: rtl/sti_clkgen.sv
`timescale 1ns/1ps
module sti_clkgen #(
  parameter int HW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [HW-1:0] half,
  output logic [HW-1:0] pcnt,
  output logic          ph_last
);
  logic [HW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart)  pcnt_d = '0;
    else if (run) pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign pcnt    = pcnt_q;
  assign ph_last = run && (pcnt_q == half - 1'b1);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pcnt_q < half)) else $error("phase counter past half period"); // R12
endmodule

// File: rtl/sti_capture.sv
`timescale 1ns/1ps
module sti_capture #(
  parameter int MAX_BITS = 32,
  parameter int IW       = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                stb,
  input  logic [IW-1:0]       idx,
  input  logic                din,
  input  logic                clk_hi,
  output logic [MAX_BITS-1:0] rx
);
  logic [MAX_BITS-1:0] rx_q, rx_d;

  always_comb begin
    rx_d = rx_q;
    if (clr)      rx_d = '0;
    else if (stb) rx_d[idx] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  assign rx = rx_q;

  AST_CAP_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> clk_hi) else $error("capture outside clock high phase"); // R4
endmodule

// File: rtl/sti_shift_engine.sv
`timescale 1ns/1ps
module sti_shift_engine
  import sti_pkg::*;
#(
  parameter int MAX_BITS  = 32,
  parameter int HALF_BASE = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rate_wr,
  input  logic [2:0]                        rate_sel,
  input  logic                              cmd_valid,
  input  logic [1:0]                        cmd_mode,
  input  logic [$clog2(MAX_BITS+1)-1:0]     cmd_nbits,
  input  logic [MAX_BITS-1:0]               cmd_dout,
  input  logic [MAX_BITS-1:0]               cmd_tms,
  input  logic [$clog2(HALF_BASE*32+1)-1:0] cmd_cap,
  input  logic                              din,
  output logic                              busy,
  output logic                              done,
  output logic                              err,
  output logic [MAX_BITS-1:0]               rx_data,
  output logic                              clk_o,
  output logic                              clk_oe,
  output logic                              sel_o,
  output logic                              sel_oe,
  output logic                              dat_o,
  output logic                              dat_oe
);
  localparam int NB_W = $clog2(MAX_BITS+1);
  localparam int HW   = $clog2(HALF_BASE*32+1);
  localparam int IW   = $clog2(MAX_BITS);

  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  st_e                 st_q, st_d;
  mode_e               mode_q, mode_d;
  logic [NB_W-1:0]     n_q, n_d, bcnt_q, bcnt_d;
  logic [IW-1:0]       idx_q, idx_d, idx_nx, idx_first;
  logic [MAX_BITS-1:0] dout_q, dout_d, tms_q, tms_d;
  logic [HW-1:0]       cap_q, cap_d;
  logic                clk_q, clk_d, oe_q, oe_d, dat_q, dat_d, sel_q, sel_d;
  logic                done_q, done_d, err_q, err_d;
  logic                restart, accept, bad, bit_last, ph_last, cap_stb;
  logic [HW-1:0]       half, pcnt;

  sti_rate_ctl #(.HALF_BASE(HALF_BASE), .HW(HW)) u_rate (
    .clk(clk), .rst_n(rst_s), .wr(rate_wr), .code(rate_sel),
    .busy(busy), .half(half)
  );

  sti_clkgen #(.HW(HW)) u_clkgen (
    .clk(clk), .rst_n(rst_s), .run(st_q != ST_IDLE), .restart(restart),
    .half(half), .pcnt(pcnt), .ph_last(ph_last)
  );

  assign cap_stb = (st_q == ST_HIGH) && (pcnt == cap_q);

  sti_capture #(.MAX_BITS(MAX_BITS), .IW(IW)) u_capture (
    .clk(clk), .rst_n(rst_s), .clr(accept), .stb(cap_stb), .idx(idx_q),
    .din(din), .clk_hi(clk_q), .rx(rx_data)
  );

  assign bad = (cmd_mode == 2'd3) || (cmd_nbits == '0) ||
               (cmd_nbits > NB_W'(MAX_BITS)) || (cmd_cap >= half);
  assign idx_first = (cmd_mode == 2'd1) ? IW'(cmd_nbits - 1'b1) : '0;
  assign idx_nx    = (mode_q == MD_SPI) ? idx_q - 1'b1 : idx_q + 1'b1;
  assign bit_last  = (bcnt_q == n_q - 1'b1);

  always_comb begin
    st_d    = st_q;   mode_d = mode_q; n_d    = n_q;   bcnt_d = bcnt_q;
    idx_d   = idx_q;  dout_d = dout_q; tms_d  = tms_q; cap_d  = cap_q;
    clk_d   = clk_q;  oe_d   = oe_q;   dat_d  = dat_q; sel_d  = sel_q;
    done_d  = 1'b0;   err_d  = 1'b0;   restart = 1'b0; accept = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (bad) begin
            err_d = 1'b1;
          end else begin
            accept  = 1'b1;
            restart = 1'b1;
            st_d    = ST_LOW;
            mode_d  = mode_e'(cmd_mode);
            n_d     = cmd_nbits;
            dout_d  = cmd_dout;
            tms_d   = cmd_tms;
            cap_d   = cmd_cap;
            bcnt_d  = '0;
            idx_d   = idx_first;
            oe_d    = 1'b1;
            clk_d   = 1'b0;
            dat_d   = cmd_dout[idx_first];
            unique case (cmd_mode)
              2'd0:    sel_d = cmd_tms[idx_first];
              2'd1:    sel_d = 1'b0;
              default: sel_d = 1'b1;
            endcase
          end
        end
      end
      ST_LOW: begin
        if (ph_last) begin
          restart = 1'b1;
          st_d    = ST_HIGH;
          clk_d   = 1'b1;
        end
      end
      ST_HIGH: begin
        if (ph_last) begin
          restart = 1'b1;
          clk_d   = 1'b0;
          if (bit_last) begin
            st_d  = ST_PARK;
            dat_d = 1'b1;
            sel_d = 1'b1;
          end else begin
            st_d   = ST_LOW;
            bcnt_d = bcnt_q + 1'b1;
            idx_d  = idx_nx;
            dat_d  = dout_q[idx_nx];
            unique case (mode_q)
              MD_JTAG: sel_d = tms_q[idx_nx];
              MD_SPI:  sel_d = 1'b0;
              default: sel_d = 1'b1;
            endcase
          end
        end
      end
      ST_PARK: begin
        if (ph_last) begin
          st_d   = ST_IDLE;
          oe_d   = 1'b0;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE; mode_q <= MD_JTAG; n_q   <= '0;   bcnt_q <= '0;
      idx_q  <= '0;      dout_q <= '0;      tms_q <= '0;   cap_q  <= '0;
      clk_q  <= 1'b0;    oe_q   <= 1'b0;    dat_q <= 1'b1; sel_q  <= 1'b1;
      done_q <= 1'b0;    err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;    mode_q <= mode_d;  n_q   <= n_d;   bcnt_q <= bcnt_d;
      idx_q  <= idx_d;   dout_q <= dout_d;  tms_q <= tms_d; cap_q  <= cap_d;
      clk_q  <= clk_d;   oe_q   <= oe_d;    dat_q <= dat_d; sel_q  <= sel_d;
      done_q <= done_d;  err_q  <= err_d;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign err    = err_q;
  assign clk_o  = clk_q;
  assign sel_o  = sel_q;
  assign dat_o  = dat_q;
  assign clk_oe = oe_q;
  assign sel_oe = oe_q;
  assign dat_oe = oe_q;

  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> !oe_q) else $error("driver enabled while idle"); // R6
  AST_LAUNCH_FALL: assert property (@(posedge clk) disable iff (!rst_s)
    (oe_q && $past(oe_q) && (dat_q != $past(dat_q) || sel_q != $past(sel_q)))
      |-> $fell(clk_q)) else $error("output moved off the falling edge"); // R3
  AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(oe_q) |-> ($past(dat_q) && $past(sel_q) && !$past(clk_q)))
    else $error("release without parking high"); // R7
  AST_SPI_SEL: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && mode_q == MD_SPI && st_q != ST_PARK) |-> !sel_q)
    else $error("spi select high in transfer"); // R5
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R11
  AST_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> !clk_q) else $error("clock high while idle"); // R12
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    err_q |-> !busy) else $error("rejected command started"); // R8
endmodule

// File: tb/sti_shift_engine_bench.sv
`timescale 1ns/1ps
module sti_shift_engine_bench;
  localparam int MB = 32;
  localparam int HB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_wr = 1'b0;
  logic [2:0]  rate_sel = 3'd0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic [5:0]  cmd_nbits = 6'd0;
  logic [31:0] cmd_dout = '0, cmd_tms = '0;
  logic [6:0]  cmd_cap = '0;
  logic        din = 1'b1;
  logic        busy, done, err, clk_o, clk_oe, sel_o, sel_oe, dat_o, dat_oe;
  logic [31:0] rx_data;

  always #2 clk = ~clk;

  sti_shift_engine #(.MAX_BITS(MB), .HALF_BASE(HB)) u_sti_shift_engine (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_sel(rate_sel),
    .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .cmd_nbits(cmd_nbits),
    .cmd_dout(cmd_dout), .cmd_tms(cmd_tms), .cmd_cap(cmd_cap), .din(din),
    .busy(busy), .done(done), .err(err), .rx_data(rx_data),
    .clk_o(clk_o), .clk_oe(clk_oe), .sel_o(sel_o), .sel_oe(sel_oe),
    .dat_o(dat_o), .dat_oe(dat_oe)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // operation context shared with the target model
  int          g_half = 4*HB, g_n = 0, g_mode = 0, g_cap = 0;
  logic [31:0] g_dout = '0, g_tms = '0, g_tgt = '0;
  int          rise_idx = 0, hi_bad = 0, move_bad = 0;
  realtime     t_rise = 0, t_fall = 0;

  logic [31:0] exp_q[$];
  int          expn_q[$];

  // target model: checks launched bits at each rise, drives din late
  initial begin
    forever begin
      @(posedge clk_o);
      begin
        automatic int j = rise_idx;
        automatic int k = (g_mode == 1) ? g_n - 1 - j : j;
        t_rise = $realtime;
        chk(dat_o === g_dout[k], (g_mode == 1) ? "R10 launch order" : "R9 launch order", dat_o, g_dout[k]);
        if (g_mode == 0)      chk(sel_o === g_tms[j], "R9 tms bit", sel_o, g_tms[j]);
        else if (g_mode == 1) chk(sel_o === 1'b0, "R5 spi select low", sel_o, 0);
        else                  chk(sel_o === 1'b1, "R5 serial select high", sel_o, 1);
        din = ~g_tgt[j];
        repeat (g_cap + 1) @(negedge clk);
        din = g_tgt[j];
        rise_idx++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk_o);
      if (int'($realtime - t_rise) != g_half*4) hi_bad++;
      t_fall = $realtime;
    end
  end

  initial begin
    forever begin
      @(negedge dat_oe);
      chk(dat_o === 1'b1 && sel_o === 1'b1 && clk_o === 1'b0, "R7 parked high",
          {dat_o, sel_o, clk_o}, 3'b110);
      chk(int'($realtime - t_fall) == g_half*4, "R7 park length",
          int'($realtime - t_fall), g_half*4);
    end
  end

  // sampled monitor: launch discipline, done pulse, scoreboard
  logic p_oe = 0, p_dat = 1, p_sel = 1, p_clk = 0, p_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dat_oe && p_oe && (dat_o !== p_dat || sel_o !== p_sel) && !(p_clk && !clk_o))
        move_bad++;
      if (done) begin
        chk(!busy && !dat_oe && !clk_oe && !sel_oe, "R11 done at release", {busy, dat_oe}, 0);
        chk(!p_done, "R11 done single cycle", p_done, 0);
        if (exp_q.size() != 0) begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic int n = expn_q.pop_front();
          chk(rx_data === e, (g_mode == 1) ? "R10 rx word" : "R9 R4 rx word", rx_data, e);
          chk(rise_idx == n, "R12 clock count", rise_idx, n);
          chk(hi_bad == 0, "R1 R2 R12 high time", hi_bad, 0);
          chk(move_bad == 0, "R3 launch on fall", move_bad, 0);
        end else begin
          chk(1'b0, "R11 unexpected done", 1, 0);
        end
      end
    end
    p_oe = dat_oe; p_dat = dat_o; p_sel = sel_o; p_clk = clk_o; p_done = done;
  end

  task automatic set_rate(input logic [2:0] c);
    @(negedge clk); rate_wr = 1'b1; rate_sel = c;
    @(negedge clk); rate_wr = 1'b0;
  endtask

  task automatic run_op(input int mode, input int n, input logic [31:0] dout,
                        input logic [31:0] tms, input logic [31:0] tgt,
                        input int cap, input int half);
    logic [31:0] e = '0;
    for (int j = 0; j < n; j++) begin
      if (mode == 1) e[n-1-j] = tgt[j];
      else           e[j]     = tgt[j];
    end
    g_mode = mode; g_n = n; g_dout = dout; g_tms = tms; g_tgt = tgt;
    g_cap = cap; g_half = half; rise_idx = 0; hi_bad = 0; move_bad = 0;
    exp_q.push_back(e);
    expn_q.push_back(n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 2'(mode); cmd_nbits = 6'(n);
    cmd_dout = dout; cmd_tms = tms; cmd_cap = 7'(cap);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R11 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bad_cmd(input int mode, input int n, input int cap, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 2'(mode); cmd_nbits = 6'(n); cmd_cap = 7'(cap);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err === 1'b1 && busy === 1'b0 && dat_oe === 1'b0, req, {err, busy, dat_oe}, 3'b100);
    @(negedge clk);
    chk(err === 1'b0 && busy === 1'b0, req, {err, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(clk_oe === 0 && sel_oe === 0 && dat_oe === 0, "R6 reset drivers off",
        {clk_oe, sel_oe, dat_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(clk_o === 0 && busy === 0 && done === 0, "R12 reset idle", {clk_o, busy, done}, 0);
    chk(dat_oe === 0, "R6 idle drivers off", dat_oe, 0);

    // R2: default code 3, half period 8
    run_op(0, 8, 32'h0000_00A5, 32'h0000_003C, 32'h0000_0096, 3, 4*HB);
    // R1: fastest rate, full width, boundary-scan
    set_rate(3'd1);
    run_op(0, 32, 32'hDEAD_BEEF, 32'h8000_0001, 32'hC3A5_5A3C, 1, HB);
    // R10 R5: SPI at code 2
    set_rate(3'd2);
    run_op(1, 12, 32'h0000_0B6D, 32'h0, 32'h0000_0E53, 2, 2*HB);
    // R5 R9: slave-serial at slowest rate
    set_rate(3'd6);
    run_op(2, 5, 32'h0000_0016, 32'h0, 32'h0000_0009, 40, 32*HB);
    // R1: invalid codes ignored
    set_rate(3'd7);
    set_rate(3'd0);
    run_op(0, 3, 32'h5, 32'h2, 32'h3, 10, 32*HB);
    // R4 boundary: capture delay one below the half period at code 4
    set_rate(3'd4);
    run_op(1, 3, 32'h6, 32'h0, 32'h5, 8*HB-1, 8*HB);
    // R8 rejections
    bad_cmd(0, 4, 8*HB, "R8 delay too long");
    bad_cmd(3, 4, 1, "R8 mode 3");
    bad_cmd(0, 0, 1, "R8 zero bits");
    chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule